// File: doc/BRIEF.md
# Windowed Event-Triggered Sampling Sequencer

This block paces the two conversions that a software-assisted buck regulator needs in each switching period. At every period start it asks for an output-voltage conversion. After a programmable gap it asks for a load-current conversion. It compares each returned sample against an acceptance window. A control event is raised only when a sample lies outside its window, so the control law runs only when something has moved, not in every period.

A voltage sample outside the fixed reference window produces a strobe that requests a PI update. A current sample outside the band around the stored baseline current produces three things at once: a feed-forward strobe carrying the signed current step, an immediate PWM restart, and a full-duty flag. The flag stays high until the next period start, so the PWM drives maximum duty for exactly one switching period. The current window is then re-centred on the new sample. One saturating counter per channel records how many events were raised, which gives a measure of how often the controller had to run.

Top module: `evt_sampler`

## Requirements
- R1: After reset, conv_start, ch_sel, v_event, i_event, pwm_restart and full_duty are 0, both event counters are 0, and the current baseline is 0.
- R2: A period_start pulse sampled at a clock edge makes conv_start high for exactly one cycle after that edge, with ch_sel = 0 (0 = voltage channel, 1 = current channel).
- R3: When smp_ready is sampled while the voltage conversion is pending, v_event is high for the one following cycle exactly when smp_data < v_lo or smp_data > v_hi (both bounds count as inside).
- R4: If the voltage smp_ready is sampled at edge E, the current conversion's conv_start is high only in the cycle after edge E+1+gap_cycles, with ch_sel = 1. Before that, conv_start stays low.
- R5: When the current sample arrives, i_event is high for one cycle exactly when |smp_data − baseline| > i_band. In that cycle i_delta holds the signed value smp_data − baseline.
- R6: On a current event, the baseline becomes the new sample, so later current samples are judged against it. The voltage window never moves.
- R7: On a current event, pwm_restart pulses in the same cycle as i_event, and full_duty goes high in that cycle. full_duty stays high until the cycle after the next period_start, when it returns to 0.
- R8: A sample inside its window raises no strobe and no restart, leaves full_duty and both counters unchanged, and does not move the baseline.
- R9: v_count and i_count each increase by one per event of their own channel and hold at 2^CW−1 once they reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| smp_data | input | W | Conversion result |
| smp_ready | input | 1 | One-cycle pulse: smp_data is valid |
| v_lo | input | W | Lower voltage bound (inclusive) |
| v_hi | input | W | Upper voltage bound (inclusive) |
| i_band | input | W | Half-width of the current window |
| gap_cycles | input | GW | Extra wait between the voltage result and the current request |
| ch_sel | output | 1 | Channel of the pending conversion (0 voltage, 1 current) |
| conv_start | output | 1 | One-cycle conversion request |
| v_event | output | 1 | Voltage sample out of window: run PI update |
| i_event | output | 1 | Current sample out of window: apply feed-forward step |
| i_delta | output | W+1 | Signed current step, valid with i_event |
| pwm_restart | output | 1 | Restart the PWM period now |
| full_duty | output | 1 | Drive maximum duty for this period |
| v_count | output | CW | Saturating voltage event count |
| i_count | output | CW | Saturating current event count |

## Verification
A wrong baseline does not appear when it is corrupted. It appears at the next current sample that should have been judged differently: the bench sees a missing or extra i_event, or a wrong i_delta, one cycle after that sample's ready, so the sample sequence runs the band edges on both sides of a moved baseline. A wrong sequencer state or gap count appears as a conversion request in the wrong cycle or on the wrong channel, and the bench checks it in every cycle between the two requests. Counter faults appear only as wrong totals, so the totals are compared after mixed in-window and out-of-window periods and again after a run long enough to saturate.

// File: rtl/evt_sampler.sv
module evt_sampler #(
  parameter int W  = 12,
  parameter int GW = 8,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_start,
  input  logic [W-1:0]      smp_data,
  input  logic              smp_ready,
  input  logic [W-1:0]      v_lo,
  input  logic [W-1:0]      v_hi,
  input  logic [W-1:0]      i_band,
  input  logic [GW-1:0]     gap_cycles,
  output logic              ch_sel,
  output logic              conv_start,
  output logic              v_event,
  output logic              i_event,
  output logic signed [W:0] i_delta,
  output logic              pwm_restart,
  output logic              full_duty,
  output logic [CW-1:0]     v_count,
  output logic [CW-1:0]     i_count
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  typedef enum logic [1:0] {IDLE, V_WAIT, GAP, I_WAIT} st_t;
  st_t st;
  logic [GW-1:0] gcnt;
  logic [W-1:0]  base;

  wire signed [W+1:0] diff   = $signed({2'b00, smp_data}) - $signed({2'b00, base});
  wire signed [W+1:0] band   = $signed({2'b00, i_band});
  wire                v_out  = (smp_data < v_lo) || (smp_data > v_hi);
  wire                i_out  = (diff > band) || (diff < -band);
  wire                v_take = (st == V_WAIT) && smp_ready && !period_start;
  wire                i_take = (st == I_WAIT) && smp_ready && !period_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      gcnt <= '0;
      base <= '0;
      ch_sel <= 1'b0;
      conv_start <= 1'b0;
      v_event <= 1'b0;
      i_event <= 1'b0;
      i_delta <= '0;
      pwm_restart <= 1'b0;
      full_duty <= 1'b0;
      v_count <= '0;
      i_count <= '0;
    end else begin
      conv_start <= 1'b0;
      v_event <= 1'b0;
      i_event <= 1'b0;
      pwm_restart <= 1'b0;
      if (period_start) begin
        st <= V_WAIT;
        ch_sel <= 1'b0;
        conv_start <= 1'b1;
        full_duty <= 1'b0;
      end else begin
        case (st)
          V_WAIT: if (v_take) begin
            st <= GAP;
            gcnt <= gap_cycles;
            if (v_out) begin
              v_event <= 1'b1;
              if (v_count != CMAX) v_count <= v_count + 1'b1;
            end
          end
          GAP: if (gcnt == '0) begin
            st <= I_WAIT;
            ch_sel <= 1'b1;
            conv_start <= 1'b1;
          end else gcnt <= gcnt - 1'b1;
          I_WAIT: if (i_take) begin
            st <= IDLE;
            if (i_out) begin
              i_event <= 1'b1;
              i_delta <= diff[W:0];
              base <= smp_data;
              pwm_restart <= 1'b1;
              full_duty <= 1'b1;
              if (i_count != CMAX) i_count <= i_count + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_conv_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_v_evt_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v_event |-> ($past(smp_ready) && !ch_sel));
  assert_i_evt_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    i_event |-> ch_sel);
  assert_restart_pairs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_duty) |-> (pwm_restart && i_event));
  assert_quiet_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_event && !i_event) |-> ($stable(v_count) && $stable(i_count)));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_count == CMAX) |=> (v_count == CMAX));
  assert_no_overflow_i_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (i_count == CMAX) |=> (i_count == CMAX));
  assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_event && i_event));
endmodule

// File: tb/evt_sampler_test.sv
module evt_sampler_test;
  localparam int W = 12, GW = 8, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic period_start = 1'b0, smp_ready = 1'b0;
  logic [W-1:0] smp_data = '0, v_lo = 12'd2000, v_hi = 12'd2200, i_band = 12'd10;
  logic [GW-1:0] gap_cycles = 8'd3;
  logic ch_sel, conv_start, v_event, i_event, pwm_restart, full_duty;
  logic signed [W:0] i_delta;
  logic [CW-1:0] v_count, i_count;

  evt_sampler #(.W(W), .GW(GW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .smp_data(smp_data),
    .smp_ready(smp_ready), .v_lo(v_lo), .v_hi(v_hi), .i_band(i_band),
    .gap_cycles(gap_cycles), .ch_sel(ch_sel), .conv_start(conv_start),
    .v_event(v_event), .i_event(i_event), .i_delta(i_delta),
    .pwm_restart(pwm_restart), .full_duty(full_duty), .v_count(v_count), .i_count(i_count));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  int base_m = 0, vcnt_m = 0, icnt_m = 0;
  bit fd_m = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe must match the head of the queue.
  always @(negedge clk) if (rst_n) begin
    if (v_event || i_event) begin
      if (exp_q.size() == 0) chk(0, v_event ? "R3 unexpected v_event" : "R5 unexpected i_event", 1, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (v_event) chk(e[31] == 1'b0, "R3 event kind", 0, int'(e[31]));
        else begin
          chk(e[31] == 1'b1, "R5 event kind", 1, int'(e[31]));
          chk(i_delta == e[W:0], "R5 i_delta", int'(i_delta), int'($signed(e[W:0])));
        end
      end
    end
  end

  task automatic run_period(input int v, input int i);
    int g;
    bit iev;
    g = int'(gap_cycles);
    @(negedge clk) period_start = 1'b1;
    @(negedge clk) period_start = 1'b0;
    chk(conv_start && !ch_sel, "R2 voltage request", int'(conv_start), 1);
    chk(!full_duty, "R7 full_duty ends at period start", int'(full_duty), 0);
    fd_m = 0;
    @(negedge clk);
    chk(!conv_start, "R2 request one cycle", int'(conv_start), 0);
    smp_data = W'(v); smp_ready = 1'b1;
    if (v < int'(v_lo) || v > int'(v_hi)) begin
      exp_q.push_back(32'h0);
      if (vcnt_m < 255) vcnt_m++;
    end
    @(negedge clk) smp_ready = 1'b0;
    for (int k = 0; k <= g; k++) begin
      chk(!conv_start, "R4 no early current request", int'(conv_start), 0);
      @(negedge clk);
    end
    chk(conv_start && ch_sel, "R4 current request timing", int'(conv_start & ch_sel), 1);
    smp_data = W'(i); smp_ready = 1'b1;
    iev = ((i - base_m) > int'(i_band)) || ((i - base_m) < -int'(i_band));
    if (iev) begin
      exp_q.push_back({1'b1, 18'd0, 13'(i - base_m)});
      base_m = i;
      fd_m = 1;
      if (icnt_m < 255) icnt_m++;
    end
    @(negedge clk) smp_ready = 1'b0;
    chk(pwm_restart == iev, "R7 restart with current event", int'(pwm_restart), int'(iev));
    chk(full_duty == fd_m, "R7 full_duty", int'(full_duty), int'(fd_m));
    @(negedge clk);
    chk(full_duty == fd_m && !pwm_restart, "R7 full_duty held, restart one cycle", int'(full_duty), int'(fd_m));
  endtask

  task automatic chk_counts(input string tag);
    chk(int'(v_count) == vcnt_m, {tag, " v_count"}, int'(v_count), vcnt_m);
    chk(int'(i_count) == icnt_m, {tag, " i_count"}, int'(i_count), icnt_m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!conv_start && !ch_sel && !v_event && !i_event && !pwm_restart && !full_duty,
        "R1 reset outputs", 0, 0);
    chk(v_count == 0 && i_count == 0, "R1 reset counters", int'(v_count) + int'(i_count), 0);
    rst_n = 1'b1;
    // R8: all inside (baseline 0, band 10, sample 5)
    run_period(2100, 5);
    chk_counts("R8 quiet period");
    // R3 boundaries inclusive, R5 step up from baseline 0
    run_period(2000, 100);
    run_period(2200, 109);       // R6: judged against new baseline 100, inside
    chk_counts("R6 re-centred window");
    run_period(1999, 111);       // R3 below, R5 +11
    run_period(2201, 100);       // R3 above, R5 -11
    run_period(2150, 90);        // R5 lower edge inside, R8
    chk_counts("R8 edge inside");
    gap_cycles = 8'd0;
    run_period(2150, 200);       // R4 zero gap, R5 event
    gap_cycles = 8'd7;
    run_period(100, 189);        // R4 long gap, R5 -11
    chk_counts("R9 counting");
    // R9 saturation of the voltage counter
    gap_cycles = 8'd0;
    for (int n = 0; n < 260; n++) run_period(0, 189);
    chk_counts("R9 saturation");
    chk(v_count == 8'd255, "R9 v_count held at max", int'(v_count), 255);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 R5 missing events", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule